// File: doc/BRIEF.md
# Audio DSP Cycle Sequencer

This block is the timing backbone of an audio signal processor that produces one output sample every 32 clock-enabled cycles. A free-running step counter walks through steps 0 to 31 and wraps without a gap. Each step is decoded into single-cycle strobes that tell the surrounding datapaths what to do in that cycle: which pipeline stage of which of the five voices runs, when the sound timers advance, when echo filter coefficients are fetched, when each output channel is scaled and sent to the converter, and when the global counter and key-on bookkeeping are updated.

Voice pipelines are staggered so that their nine stages overlap across the frame, and the first voices wrap around the frame boundary. A two-bit frame counter divides the frame rate by four for the slow timers. The clock enable freezes the sequence: while it is low the step holds and no strobe fires. The consuming datapaths are not part of this block.

Top module: `dsp_step_sequencer`

## Requirements
- R1: `step_o` advances by one (31 wraps to 0) at each rising clock edge where `en` is high and `rst` is low, and holds its value when `en` is low.
- R2: A synchronous reset (`rst` high at a rising edge) sets the step to 0 and the frame count to 0; every strobe output is low whenever `rst` is high or `en` is low.
- R3: `timer_tick_o[2]` fires at steps 0 and 16 of every frame.
- R4: `timer_tick_o[0]` and `timer_tick_o[1]` fire together at step 0 only in frames whose frame count is 0; the count is 0 after reset and advances (mod 4) as step 31 completes, so the first step 0 after reset ticks them and then every fourth frame.
- R5: `voice_stb_o[v*9+k-1]` is the strobe of stage Sk of voice v. Voice 0 runs S1 at 17, S2 at 21, S3 at 22, S4 at 31, S5..S9 at 0..4; `v0_s3_phase_o` bits 0, 1, 2 mark the three phases of its S3 at steps 22, 25 and 30.
- R6: Voice 1 runs S1 at step 20 and S2..S9 at steps 0..7; voice 2 runs S1 at step 31 and S2..S9 at steps 3..10.
- R7: Voice 3 runs S1 at step 2 and S2..S9 at steps 6..13; voice 4 runs S1 at step 5 and S2..S9 at steps 9..16.
- R8: `fir_load_o[k]` loads echo coefficient k: bit 0 at step 22, bits 1 and 2 at step 23, bits 3 to 5 at step 24, bits 6 and 7 at step 25.
- R9: `left_out_o` (left volume and converter output) fires at step 26 and `right_out_o` at step 27.
- R10: `counter_update_o` and `kon_clear_o` both fire at step 29 and nowhere else.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| en | input | 1 | Clock enable; one step per enabled cycle |
| step_o | output | 5 | Current step number |
| voice_stb_o | output | 45 | Voice stage strobes, bit v*9+k-1 for stage Sk of voice v |
| v0_s3_phase_o | output | 3 | Voice 0 stage S3 phase strobes (steps 22, 25, 30) |
| timer_tick_o | output | 3 | Timer first-stage ticks, bit n for timer n |
| fir_load_o | output | 8 | Echo filter coefficient load strobes |
| left_out_o | output | 1 | Left channel volume and converter output strobe |
| right_out_o | output | 1 | Right channel volume and converter output strobe |
| counter_update_o | output | 1 | Global counter update strobe |
| kon_clear_o | output | 1 | Key-on clear strobe |

## Verification
The assertions take for granted that `rst` and `en` are clean synchronous levels sampled at the rising edge, and that no stage relation is judged across a cycle where reset was high. The stimulus changes both inputs only at the falling edge, draws the enable from a seeded random stream so steps are frozen for irregular stretches, and inserts one long fully enabled run plus a mid-run reset so that the wrap of the frame counter and the return to step 0 are both reached.

// File: rtl/dsp_seq_pkg.sv
package dsp_seq_pkg;

    localparam int NUM_STEPS   = 32;
    localparam int STEP_W      = $clog2(NUM_STEPS);
    localparam int NUM_VOICES  = 5;
    localparam int NUM_STAGES  = 9;
    localparam int NUM_COEFS   = 8;
    localparam int NUM_TIMERS  = 3;
    localparam int VOICE_BITS  = NUM_VOICES * NUM_STAGES;

    // Step at which stage index s (0 = S1) of voice v is scheduled.
    function automatic int stage_step(input int v, input int s);
        int at;
        case (v)
            0: begin
                case (s)
                    0:       at = 17;
                    1:       at = 21;
                    2:       at = 22;
                    3:       at = 31;
                    default: at = s - 4;
                endcase
            end
            1:       at = (s == 0) ? 20 : s - 1;
            2:       at = (s == 0) ? 31 : s + 2;
            3:       at = (s == 0) ? 2  : s + 5;
            default: at = (s == 0) ? 5  : s + 8;
        endcase
        return at;
    endfunction

endpackage

// File: rtl/dsp_seq_counter.sv
module dsp_seq_counter
    import dsp_seq_pkg::*;
#(
    parameter int FRAME_DIV = 4,
    localparam int FRAME_W  = (FRAME_DIV > 1) ? $clog2(FRAME_DIV) : 1
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               en,
    output logic [STEP_W-1:0]  step_o,
    output logic [FRAME_W-1:0] frame_o
);

    localparam logic [STEP_W-1:0]  LAST_STEP  = STEP_W'(NUM_STEPS - 1);
    localparam logic [FRAME_W-1:0] LAST_FRAME = FRAME_W'(FRAME_DIV - 1);

    typedef struct packed {
        logic [STEP_W-1:0]  step;
        logic [FRAME_W-1:0] frame;
    } seq_state_t;

    seq_state_t state_d, state_q;

    always_comb begin
        state_d = state_q;
        if (en) begin
            if (state_q.step == LAST_STEP) begin
                state_d.step  = '0;
                state_d.frame = (state_q.frame == LAST_FRAME) ? '0 : state_q.frame + 1'b1;
            end else begin
                state_d.step = state_q.step + 1'b1;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= '0;
        end else begin
            state_q <= state_d;
        end
    end

    assign step_o  = state_q.step;
    assign frame_o = state_q.frame;

    // R1: one step per enabled cycle, wrapping to zero
    assert_step_advance_R1: assert property (@(posedge clk) disable iff (rst)
        en |=> (step_o == (($past(step_o) == LAST_STEP) ? '0 : $past(step_o) + 1'b1)));

    // R1: no enable, no movement
    assert_step_hold_R1: assert property (@(posedge clk) disable iff (rst)
        !en |=> $stable(step_o) && $stable(frame_o));

    // R4: frame count only moves when a frame completes
    assert_frame_move_R4: assert property (@(posedge clk) disable iff (rst)
        (en && step_o != LAST_STEP) |=> $stable(frame_o));

endmodule

// File: rtl/dsp_seq_voice_decode.sv
module dsp_seq_voice_decode
    import dsp_seq_pkg::*;
(
    input  logic                  clk,
    input  logic                  rst,
    input  logic                  active_i,
    input  logic [STEP_W-1:0]     step_i,
    output logic [VOICE_BITS-1:0] voice_stb_o,
    output logic [2:0]            s3_phase_o
);

    for (genvar v = 0; v < NUM_VOICES; v++) begin : g_voice
        for (genvar s = 0; s < NUM_STAGES; s++) begin : g_stage
            localparam logic [STEP_W-1:0] AT = STEP_W'(stage_step(v, s));
            assign voice_stb_o[v*NUM_STAGES + s] = active_i && (step_i == AT);
        end

        // R5..R7: a voice is in at most one stage per cycle
        assert_one_stage_R6: assert property (@(posedge clk) disable iff (rst)
            $onehot0(voice_stb_o[v*NUM_STAGES +: NUM_STAGES]));
    end

    localparam logic [STEP_W-1:0] S3A_STEP = STEP_W'(stage_step(0, 2));
    localparam logic [STEP_W-1:0] S3B_STEP = STEP_W'(25);
    localparam logic [STEP_W-1:0] S3C_STEP = STEP_W'(30);

    assign s3_phase_o[0] = active_i && (step_i == S3A_STEP);
    assign s3_phase_o[1] = active_i && (step_i == S3B_STEP);
    assign s3_phase_o[2] = active_i && (step_i == S3C_STEP);

    // R5: the first S3 phase coincides with the voice 0 S3 stage strobe
    assert_s3_first_phase_R5: assert property (@(posedge clk) disable iff (rst)
        s3_phase_o[0] |-> voice_stb_o[2]);

    // R5: S3 phases never overlap
    assert_s3_phase_onehot_R5: assert property (@(posedge clk) disable iff (rst)
        $onehot0(s3_phase_o));

endmodule

// File: rtl/dsp_seq_global_decode.sv
module dsp_seq_global_decode
    import dsp_seq_pkg::*;
#(
    parameter int FRAME_W = 2
) (
    input  logic                  clk,
    input  logic                  rst,
    input  logic                  active_i,
    input  logic [STEP_W-1:0]     step_i,
    input  logic [FRAME_W-1:0]    frame_i,
    output logic [NUM_TIMERS-1:0] timer_tick_o,
    output logic [NUM_COEFS-1:0]  fir_load_o,
    output logic                  left_out_o,
    output logic                  right_out_o,
    output logic                  counter_update_o,
    output logic                  kon_clear_o
);

    localparam logic [STEP_W-1:0] HALF_STEP = STEP_W'(NUM_STEPS / 2);

    logic [NUM_COEFS-1:0] fir_sel;

    always_comb begin
        case (step_i)
            STEP_W'(22): fir_sel = 8'b0000_0001;
            STEP_W'(23): fir_sel = 8'b0000_0110;
            STEP_W'(24): fir_sel = 8'b0011_1000;
            STEP_W'(25): fir_sel = 8'b1100_0000;
            default:     fir_sel = '0;
        endcase
    end

    logic at_zero;
    assign at_zero = (step_i == '0);

    assign timer_tick_o[2]   = active_i && (at_zero || step_i == HALF_STEP);
    assign timer_tick_o[0]   = active_i && at_zero && (frame_i == '0);
    assign timer_tick_o[1]   = timer_tick_o[0];
    assign fir_load_o        = active_i ? fir_sel : '0;
    assign left_out_o        = active_i && (step_i == STEP_W'(26));
    assign right_out_o       = active_i && (step_i == STEP_W'(27));
    assign counter_update_o  = active_i && (step_i == STEP_W'(29));
    assign kon_clear_o       = counter_update_o;

    // R4: slow timers only tick in a cycle where the fast timer also ticks
    assert_slow_with_fast_R4: assert property (@(posedge clk) disable iff (rst)
        timer_tick_o[0] |-> timer_tick_o[2] && timer_tick_o[1]);

    // R9: channels are never output in the same cycle
    assert_channels_apart_R9: assert property (@(posedge clk) disable iff (rst)
        !(left_out_o && right_out_o));

    // R10: no update coincides with a channel output or coefficient load
    assert_update_alone_R10: assert property (@(posedge clk) disable iff (rst)
        counter_update_o |-> !left_out_o && !right_out_o && fir_load_o == '0);

    // R8: coefficient loads never overlap channel outputs
    assert_fir_apart_R8: assert property (@(posedge clk) disable iff (rst)
        (fir_load_o != '0) |-> !left_out_o && !right_out_o);

endmodule

// File: rtl/dsp_step_sequencer.sv
module dsp_step_sequencer
    import dsp_seq_pkg::*;
#(
    parameter int TIMER_SLOW_DIV = 4,
    localparam int FRAME_W = (TIMER_SLOW_DIV > 1) ? $clog2(TIMER_SLOW_DIV) : 1
) (
    input  logic                  clk,
    input  logic                  rst,
    input  logic                  en,
    output logic [STEP_W-1:0]     step_o,
    output logic [VOICE_BITS-1:0] voice_stb_o,
    output logic [2:0]            v0_s3_phase_o,
    output logic [NUM_TIMERS-1:0] timer_tick_o,
    output logic [NUM_COEFS-1:0]  fir_load_o,
    output logic                  left_out_o,
    output logic                  right_out_o,
    output logic                  counter_update_o,
    output logic                  kon_clear_o
);

    logic [FRAME_W-1:0] frame;
    logic               active;

    assign active = en && !rst;

    dsp_seq_counter #(.FRAME_DIV(TIMER_SLOW_DIV)) u_counter (
        .clk     (clk),
        .rst     (rst),
        .en      (en),
        .step_o  (step_o),
        .frame_o (frame)
    );

    dsp_seq_voice_decode u_voice (
        .clk         (clk),
        .rst         (rst),
        .active_i    (active),
        .step_i      (step_o),
        .voice_stb_o (voice_stb_o),
        .s3_phase_o  (v0_s3_phase_o)
    );

    dsp_seq_global_decode #(.FRAME_W(FRAME_W)) u_global (
        .clk              (clk),
        .rst              (rst),
        .active_i         (active),
        .step_i           (step_o),
        .frame_i          (frame),
        .timer_tick_o     (timer_tick_o),
        .fir_load_o       (fir_load_o),
        .left_out_o       (left_out_o),
        .right_out_o      (right_out_o),
        .counter_update_o (counter_update_o),
        .kon_clear_o      (kon_clear_o)
    );

    // R2: with the enable low nothing is strobed
    assert_quiet_idle_R2: assert property (@(posedge clk) disable iff (rst)
        !en |-> (voice_stb_o == '0) && (timer_tick_o == '0) && (fir_load_o == '0)
                && !left_out_o && !right_out_o && !counter_update_o);

endmodule

// File: tb/dsp_step_sequencer_bench.sv
module dsp_step_sequencer_bench;
    import dsp_seq_pkg::*;

    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        en  = 1'b0;
    logic [4:0]  step_o;
    logic [44:0] voice_stb_o;
    logic [2:0]  v0_s3_phase_o;
    logic [2:0]  timer_tick_o;
    logic [7:0]  fir_load_o;
    logic        left_out_o, right_out_o, counter_update_o, kon_clear_o;

    int n_checks = 0;
    int n_fail   = 0;
    int m_step   = 0;
    int m_frame  = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    dsp_step_sequencer u_dsp_step_sequencer (
        .clk              (clk),
        .rst              (rst),
        .en               (en),
        .step_o           (step_o),
        .voice_stb_o      (voice_stb_o),
        .v0_s3_phase_o    (v0_s3_phase_o),
        .timer_tick_o     (timer_tick_o),
        .fir_load_o       (fir_load_o),
        .left_out_o       (left_out_o),
        .right_out_o      (right_out_o),
        .counter_update_o (counter_update_o),
        .kon_clear_o      (kon_clear_o)
    );

    // Schedules from R5, R6, R7: steps of S1..S9 per voice
    function automatic int sched(input int v, input int k);
        int t0[9] = '{17, 21, 22, 31, 0, 1, 2, 3, 4};
        int t1[9] = '{20, 0, 1, 2, 3, 4, 5, 6, 7};
        int t2[9] = '{31, 3, 4, 5, 6, 7, 8, 9, 10};
        int t3[9] = '{2, 6, 7, 8, 9, 10, 11, 12, 13};
        int t4[9] = '{5, 9, 10, 11, 12, 13, 14, 15, 16};
        case (v)
            0: return t0[k];
            1: return t1[k];
            2: return t2[k];
            3: return t3[k];
            default: return t4[k];
        endcase
    endfunction

    function automatic logic [8:0] exp_voice(input int v, input int st, input bit act);
        logic [8:0] r = '0;
        for (int k = 0; k < 9; k++) r[k] = act && (sched(v, k) == st);
        return r;
    endfunction

    function automatic logic [7:0] exp_fir(input int st, input bit act);
        if (!act) return 8'h00;
        case (st)
            22: return 8'h01;
            23: return 8'h06;
            24: return 8'h38;
            25: return 8'hC0;
            default: return 8'h00;
        endcase
    endfunction

    task automatic check(input string tag, input logic [63:0] act, input logic [63:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %0h expected %0h (step %0d frame %0d)",
                     tag, act, exp, m_step, m_frame);
        end
    endtask

    task automatic cycle(input bit r, input bit e);
        bit act;
        @(negedge clk);
        rst = r;
        en  = e;
        #1;
        act = e && !r;
        if (!act) begin
            // R2: all strobes quiet under reset or without enable
            check("R2 quiet", {voice_stb_o, v0_s3_phase_o, timer_tick_o, fir_load_o,
                               left_out_o, right_out_o, counter_update_o, kon_clear_o}, '0);
        end
        check("R1 step", 64'(step_o), 64'(m_step));
        check("R5 voice0", {voice_stb_o[8:0], v0_s3_phase_o},
              {exp_voice(0, m_step, act),
               act && m_step == 30, act && m_step == 25, act && m_step == 22});
        check("R6 voice1-2", voice_stb_o[26:9],
              {exp_voice(2, m_step, act), exp_voice(1, m_step, act)});
        check("R7 voice3-4", voice_stb_o[44:27],
              {exp_voice(4, m_step, act), exp_voice(3, m_step, act)});
        check("R3 timer2", 64'(timer_tick_o[2]), 64'(act && (m_step == 0 || m_step == 16)));
        check("R4 timer01", 64'(timer_tick_o[1:0]),
              (act && m_step == 0 && m_frame == 0) ? 64'd3 : 64'd0);
        check("R8 fir", 64'(fir_load_o), 64'(exp_fir(m_step, act)));
        check("R9 channels", {left_out_o, right_out_o},
              {act && m_step == 26, act && m_step == 27});
        check("R10 update", {counter_update_o, kon_clear_o},
              {act && m_step == 29, act && m_step == 29});
        @(posedge clk);
        if (r) begin
            m_step  = 0;
            m_frame = 0;
        end else if (e) begin
            if (m_step == 31) begin
                m_step  = 0;
                m_frame = (m_frame + 1) % 4;
            end else begin
                m_step++;
            end
        end
    endtask

    initial begin
        #(CLK_PERIOD * 150000);
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("[TB] %0d tests run, %0d failed", n_checks, n_fail);
        $finish;
    end

    initial begin
        void'($urandom(32'd20240607));
        // R2: reset held with enable high
        for (int i = 0; i < 3; i++) cycle(1'b1, 1'b1);
        // R4: five full frames enabled, frame count wraps
        for (int i = 0; i < 5 * 32; i++) cycle(1'b0, 1'b1);
        // R1: enable low for a while holds step
        for (int i = 0; i < 7; i++) cycle(1'b0, 1'b0);
        // Random enable
        for (int i = 0; i < 3000; i++) cycle(1'b0, ($urandom % 10) < 7);
        // R2: mid-run reset, then restart
        cycle(1'b1, 1'b0);
        cycle(1'b1, 1'b1);
        for (int i = 0; i < 140; i++) cycle(1'b0, 1'b1);
        for (int i = 0; i < 1000; i++) cycle(1'b0, ($urandom % 4) != 0);
        $display("[TB] %0d tests run, %0d failed", n_checks, n_fail);
        $finish;
    end

endmodule